// File: doc/BRIEF.md
# 8-bit Program Status Word Unit

This block keeps the status word of a small accumulator processor. On each cycle where the datapath flags an ALU operation, it works out the carry or borrow, the nibble carry and the signed overflow from the two operands, the carry-in and the operation code. It stores those flags in an 8-bit register. A parity bit follows the accumulator value on every cycle, whether or not an operation is reported.

Software can replace the whole word in one write, or set or clear one bit chosen by its index. The two bank-select bits are turned into the base address of the active window of eight working registers in internal RAM. Register n of the active window sits at that base plus n.

Top module: `psw_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `psw_q` to 0x00 on the next clock edge, and `bank_base` then reads 0.
- R2: Word layout: bit 7 carry (CY), bit 6 nibble carry (AC), bit 5 user flag, bits 4:3 bank select (bit 4 is the upper bit), bit 2 signed overflow (OV), bit 1 spare, bit 0 accumulator parity. Bits 5, 3, 4 and 1 are only changed by software.
- R3: `op_code` 0 is add (carry-in ignored), 1 is add-with-carry, 2 is subtract-with-borrow and 3 is logical. With `op_valid` high, CY becomes 1 after the next edge when the 8-bit addition carries out of bit 7, or when the subtraction a - b - carry_in needs a borrow. Otherwise CY becomes 0.
- R4: AC is set by the same rule as CY, but for the carry or borrow between bit 3 and bit 4.
- R5: OV is set when the signed two's-complement result of the add or subtract lies outside -128..+127, and is cleared otherwise.
- R6: Bit 0 of `psw_q` equals the XOR of all `acc_in` bits sampled at the previous edge (1 for an odd count of ones). Software writes to bit 0 have no effect on it.
- R7: A logical operation (`op_code` 3) leaves CY, AC and OV unchanged.
- R8: With `sw_wr_en` high, bits 7:1 of `psw_q` take `sw_wr_data[7:1]` after the next edge.
- R9: With `sw_bit_en` high, the bit indexed by `sw_bit_sel` takes `sw_bit_val` after the next edge. When a whole-word write happens in the same cycle, this bit operation is applied on top of it.
- R10: When software access and an ALU update arrive in the same cycle, the software value wins on every bit it touches. The ALU still updates the flag bits that software leaves alone.
- R11: `bank_base` equals bank select times 8: bank 0 gives 0x00, bank 1 gives 0x08, bank 2 gives 0x10, bank 3 gives 0x18.
- R12: An ALU update never changes bits 5, 4, 3 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An ALU operation completes this cycle |
| op_code | input | 2 | 0 add, 1 add with carry, 2 subtract with borrow, 3 logical |
| opnd_a | input | 8 | First ALU operand |
| opnd_b | input | 8 | Second ALU operand |
| carry_in | input | 1 | Carry or borrow input of the operation |
| acc_in | input | 8 | Current accumulator value |
| sw_wr_en | input | 1 | Software whole-word write strobe |
| sw_wr_data | input | 8 | Software write value |
| sw_bit_en | input | 1 | Software single-bit write strobe |
| sw_bit_sel | input | 3 | Index of the bit to write |
| sw_bit_val | input | 1 | Value for the indexed bit |
| psw_q | output | 8 | Stored status word |
| bank_base | output | 5 | RAM base address of the active register window |

## Verification
Overflow and nibble carry with a live carry-in or borrow-in appear only for narrow operand pairs near 0x7F/0x80 and near nibble wraps. The bench therefore sweeps every value of the first operand against a dense stride of the second, for each arithmetic code and both carry-in values. It derives the expected flags from plain signed and unsigned integer sums.

Same-cycle clashes between a software write and an ALU update cannot be observed in normal operation, because one instruction does only one of the two. The bench drives both strobes together and checks which bits each source controls.

// File: rtl/psw_pkg.sv
package psw_pkg;

  localparam int W      = 8;
  localparam int NIB    = 4;
  localparam int SEL_W  = $clog2(W);

  localparam int CY_POS  = 7;
  localparam int AC_POS  = 6;
  localparam int UF_POS  = 5;
  localparam int BS_HI   = 4;
  localparam int BS_LO   = 3;
  localparam int OV_POS  = 2;
  localparam int SP_POS  = 1;
  localparam int PAR_POS = 0;
  localparam int BANK_W  = BS_HI - BS_LO + 1;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_ADDC  = 2'd1,
    OP_SUBB  = 2'd2,
    OP_LOGIC = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;

  // carry out of the low k bits of a + b + c
  function automatic logic carry_out_of(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic c, input int k);
    logic [W:0] m;
    logic [W:0] s;
    m = ({{W{1'b0}}, 1'b1} << k) - {{W{1'b0}}, 1'b1};
    s = ({1'b0, a} & m) + ({1'b0, b} & m) + {{W{1'b0}}, c};
    return s[k];
  endfunction

  // borrow into bit k when the low k bits compute a - b - c
  function automatic logic borrow_into(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic c, input int k);
    logic [W:0] m;
    m = ({{W{1'b0}}, 1'b1} << k) - {{W{1'b0}}, 1'b1};
    return (({1'b0, a} & m) < (({1'b0, b} & m) + {{W{1'b0}}, c}));
  endfunction

endpackage

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
  import psw_pkg::*;
(
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic         is_arith,
  output logic         c_nib,
  output logic         c_into_msb,
  output logic         c_out_msb,
  output arith_flags_t flags
);

  logic is_sub;
  logic use_c;

  assign is_sub   = (op == OP_SUBB);
  assign is_arith = (op != OP_LOGIC);
  assign use_c    = (op == OP_ADD) ? 1'b0 : cin;

  always_comb begin
    if (is_sub) begin
      c_nib      = borrow_into(a, b, use_c, NIB);
      c_into_msb = borrow_into(a, b, use_c, W - 1);
      c_out_msb  = borrow_into(a, b, use_c, W);
    end else begin
      c_nib      = carry_out_of(a, b, use_c, NIB);
      c_into_msb = carry_out_of(a, b, use_c, W - 1);
      c_out_msb  = carry_out_of(a, b, use_c, W);
    end
  end

  assign flags.cy = c_out_msb;
  assign flags.ac = c_nib;
  assign flags.ov = c_into_msb ^ c_out_msb;

endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_en,
  input  logic             hw_arith,
  input  arith_flags_t     hw_flags,
  input  logic             par_in,
  input  logic             sw_wr_en,
  input  logic [W-1:0]     sw_wr_data,
  input  logic             bit_en,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic             bit_val,
  output logic [W-1:0]     q
);

  logic [W-1:0] bit_hit;
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_hit
    assign bit_hit[i] = bit_en && (bit_sel == SEL_W'(i));
  end

  always_comb begin
    nxt = q;
    if (hw_en && hw_arith) begin
      nxt[CY_POS] = hw_flags.cy;
      nxt[AC_POS] = hw_flags.ac;
      nxt[OV_POS] = hw_flags.ov;
    end
    if (sw_wr_en) nxt = sw_wr_data;
    nxt = (nxt & ~bit_hit) | (bit_hit & {W{bit_val}});
    nxt[PAR_POS] = par_in;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d) AST_RESET_CLEAR: assert (q == '0); // R1
  end

  AST_PARITY_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q[PAR_POS] == $past(par_in))); // R6

  AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
    (sw_wr_en && !bit_en) |=> (q[W-1:1] == $past(sw_wr_data[W-1:1]))); // R10

  AST_LOGIC_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (hw_en && !hw_arith && !sw_wr_en && !bit_en) |=> (q[W-1:1] == $past(q[W-1:1]))); // R7

  AST_HW_KEEPS_USER: assert property (@(posedge clk) disable iff (rst)
    (hw_en && !sw_wr_en && !bit_en) |=>
      ((q[BS_HI:BS_LO] == $past(q[BS_HI:BS_LO])) && (q[UF_POS] == $past(q[UF_POS]))
       && (q[SP_POS] == $past(q[SP_POS])))); // R12

endmodule

// File: rtl/psw_bank_map.sv
module psw_bank_map #(
  parameter int BANK_W = 2,
  parameter int REGS   = 8,
  localparam int OFF_W = $clog2(REGS),
  localparam int ADR_W = BANK_W + OFF_W
) (
  input  logic [BANK_W-1:0] bank,
  output logic [ADR_W-1:0]  base
);

  assign base = {bank, {OFF_W{1'b0}}};

endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [1:0]       op_code,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic             carry_in,
  input  logic [W-1:0]     acc_in,
  input  logic             sw_wr_en,
  input  logic [W-1:0]     sw_wr_data,
  input  logic             sw_bit_en,
  input  logic [SEL_W-1:0] sw_bit_sel,
  input  logic             sw_bit_val,
  output logic [W-1:0]     psw_q,
  output logic [4:0]       bank_base
);

  localparam int REGS_PER_BANK = 8;

  logic         is_arith;
  logic         c_nib;
  logic         c_into_msb;
  logic         c_out_msb;
  arith_flags_t flags;
  logic         acc_par;

  assign acc_par = ^acc_in;

  psw_flag_calc u_calc (
    .op         (op_code),
    .a          (opnd_a),
    .b          (opnd_b),
    .cin        (carry_in),
    .is_arith   (is_arith),
    .c_nib      (c_nib),
    .c_into_msb (c_into_msb),
    .c_out_msb  (c_out_msb),
    .flags      (flags)
  );

  psw_reg u_reg (
    .clk        (clk),
    .rst        (rst),
    .hw_en      (op_valid),
    .hw_arith   (is_arith),
    .hw_flags   (flags),
    .par_in     (acc_par),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .bit_en     (sw_bit_en),
    .bit_sel    (sw_bit_sel),
    .bit_val    (sw_bit_val),
    .q          (psw_q)
  );

  psw_bank_map #(.BANK_W(BANK_W), .REGS(REGS_PER_BANK)) u_bank (
    .bank (psw_q[BS_HI:BS_LO]),
    .base (bank_base)
  );

  // signed add overflow is only possible between operands of equal sign
  AST_OV_SIGN: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ADD && flags.ov) |-> (opnd_a[W-1] == opnd_b[W-1])); // R5

  // a subtraction that borrows out with no borrow into the top bit has a < b there
  AST_CY_SUB: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SUBB && c_out_msb && !c_into_msb) |-> (!opnd_a[W-1] && opnd_b[W-1])); // R3

endmodule

// File: tb/psw_unit_test.sv
`timescale 1ns/1ps
module psw_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [1:0] op_code = 2'd0;
  logic [7:0] opnd_a = 8'd0, opnd_b = 8'd0;
  logic       carry_in = 1'b0;
  logic [7:0] acc_in = 8'd0;
  logic       sw_wr_en = 1'b0;
  logic [7:0] sw_wr_data = 8'd0;
  logic       sw_bit_en = 1'b0;
  logic [2:0] sw_bit_sel = 3'd0;
  logic       sw_bit_val = 1'b0;
  logic [7:0] psw_q;
  logic [4:0] bank_base;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  psw_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .acc_in(acc_in),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .sw_bit_en(sw_bit_en),
    .sw_bit_sel(sw_bit_sel), .sw_bit_val(sw_bit_val),
    .psw_q(psw_q), .bank_base(bank_base)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; sets every input, then waits one cycle
  task automatic step(input logic ov, input int op, input int a, input int b, input int c,
                      input int acc, input logic wr, input int wd,
                      input logic be, input int bs, input logic bv);
    op_valid = ov; op_code = op[1:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
    carry_in = c[0]; acc_in = acc[7:0]; sw_wr_en = wr; sw_wr_data = wd[7:0];
    sw_bit_en = be; sw_bit_sel = bs[2:0]; sw_bit_val = bv;
    @(negedge clk);
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int par8(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n % 2;
  endfunction

  // returns {cy, ac, ov, result[7:0]} from integer arithmetic
  function automatic int model(input int op, input int a, input int b, input int c);
    int cc, full, lo, sr, cy, ac, ov;
    cc = (op == 0) ? 0 : c;
    if (op < 2) begin
      full = a + b + cc; lo = (a % 16) + (b % 16) + cc; sr = sgn(a) + sgn(b) + cc;
      cy = (full > 255); ac = (lo > 15);
    end else begin
      full = a - b - cc; lo = (a % 16) - (b % 16) - cc; sr = sgn(a) - sgn(b) - cc;
      cy = (full < 0); ac = (lo < 0);
    end
    ov = (sr > 127 || sr < -128);
    return (cy << 10) | (ac << 9) | (ov << 8) | (full & 255);
  endfunction

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int m, res, exp_w;
    repeat (3) @(negedge clk);
    chk("R1 reset word", psw_q, 8'h00);
    chk("R1 reset bank base", bank_base, 0);
    rst = 1'b0;

    // R11, R8: bank windows through whole-word writes
    for (int bk = 0; bk < 4; bk++) begin
      step(0, 0, 0, 0, 0, 0, 1, bk << 3, 0, 0, 0);
      chk("R8 word write", psw_q, bk << 3);
      chk("R11 bank base", bank_base, bk * 8);
    end
    // R2, R6: write all ones, parity stays with accumulator (0)
    step(0, 0, 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0);
    chk("R6 sw cannot set parity", psw_q, 8'hFE);
    step(0, 0, 0, 0, 0, 8'h01, 1, 8'h00, 0, 0, 0);
    chk("R6 parity odd acc", psw_q, 8'h01);
    step(0, 0, 0, 0, 0, 8'h03, 0, 0, 0, 0, 0);
    chk("R6 parity even acc", psw_q, 8'h00);

    // R9: each bit set then cleared (bit 0 ignores software)
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, i, 1);
      chk("R9 bit set", psw_q, (i == 0) ? 0 : (1 << i));
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, i, 0);
      chk("R9 bit clear", psw_q, 0);
    end
    // R9: bit op layered on a word write in the same cycle
    step(0, 0, 0, 0, 0, 0, 1, 8'h3A, 1, 5, 0);
    chk("R9 bit op over word write", psw_q, 8'h1A);

    // preload user field, bank 3, spare bit
    step(0, 0, 0, 0, 0, 0, 1, 8'h3A, 0, 0, 0);
    chk("R8 preload", psw_q, 8'h3A);

    // R3 R4 R5 R6 R12 sweep
    for (int op = 0; op < 3; op++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b += 5) begin
            m = model(op, a, b, c);
            res = m & 255;
            step(1, op, a, b, c, res, 0, 0, 0, 0, 0);
            exp_w = (((m >> 10) & 1) << 7) | (((m >> 9) & 1) << 6) | 8'h38
                  | (((m >> 8) & 1) << 2) | 8'h02 | par8(res);
            chk("R3 R4 R5 R6 R12 arith flags", psw_q, exp_w);
          end

    // R7: logical op keeps CY and AC
    step(0, 0, 0, 0, 0, 0, 1, 8'h00, 0, 0, 0);
    step(1, 0, 8'hFF, 8'h01, 0, 8'h00, 0, 0, 0, 0, 0);
    chk("R3 carry out of add", psw_q, 8'hC0);
    step(1, 3, 8'h12, 8'h34, 1, 8'h07, 0, 0, 0, 0, 0);
    chk("R7 logic keeps CY AC", psw_q, 8'hC1);
    step(1, 0, 8'h7F, 8'h01, 0, 8'h80, 0, 0, 0, 0, 0);
    chk("R5 overflow positive", psw_q, 8'h45);
    step(1, 3, 8'hFF, 8'hFF, 0, 8'h00, 0, 0, 0, 0, 0);
    chk("R7 logic keeps OV", psw_q, 8'h44);
    step(1, 2, 8'h80, 8'h00, 1, 8'h7F, 0, 0, 0, 0, 0);
    chk("R5 overflow with borrow-in", psw_q, 8'h45);

    // R10: software write beats a same-cycle ALU update
    step(1, 0, 8'hFF, 8'h01, 0, 8'h01, 1, 8'h00, 0, 0, 0);
    chk("R10 word write wins", psw_q, 8'h01);
    step(1, 0, 8'hFF, 8'hFF, 0, 8'hFE, 0, 0, 1, 7, 0);
    chk("R10 bit clear wins, AC from ALU", psw_q, 8'h41);
    step(1, 2, 8'h00, 8'h01, 0, 8'hFF, 1, 8'h18, 0, 0, 0);
    chk("R10 bank write with subtract", psw_q, 8'h18);
    chk("R11 bank 3 after clash", bank_base, 8'h18);

    // R1: reset from a non-zero word
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears word", psw_q, 8'h00);
    chk("R1 reset bank base", bank_base, 0);
    rst = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule